// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block turns the opening byte of an instruction, together with an optional follow-on byte, into decoded fields for a small processor. The processor has a 16-bit datapath, four registers and a byte-wide instruction encoding. The decoded fields are the instruction class, two 2-bit register selectors, an operation field, an 8-bit immediate and the instruction length in bytes. Several opcode groups change meaning when their two register fields hold the same value, and the decoder resolves those aliases itself. Every field is settled combinationally and then held in one output register stage.

A fetch unit places the opening byte on `op_byte`. When the length is two, it also places the next byte on `ext_byte` and raises `ext_valid`. Until the follow-on byte is present, a two-byte instruction is reported as incomplete, and its class and fields read zero. A reserved byte is flagged as illegal on the strength of the opening byte alone.

Top module: `vlen_decoder`

## Requirements
- R1: Every output is registered, so it reflects the inputs present at the previous rising clock edge. While `rst` is high at an edge, every output is cleared to zero, and that includes `len_o`.
- R2: Class codes on `cls_o`: 0 none, 1 halt, 2 no-op, 3 reg-reg ALU, 4 jump-and-link, 5 move, 6 one-operand ALU, 7 register load/store, 8 compare-branch, 9 relative jump, 10 absolute load/store, 11 add-immediate, 12 immediate ALU, 13 load-low, 14 load-high, 15 stack/offset memory.
- R3: 0x00 is halt and 0x10 is no-op. Any other byte with bit 7 clear is class 3, with `fn_o` = bits 6:4, `ra_o` = bits 3:2 and `rb_o` = bits 1:0.
- R4: A byte 1000_aabb is class 4 when aa equals bb and class 5 otherwise, with `ra_o` = aa and `rb_o` = bb.
- R5: A byte 1001_aaoo is class 6, with `ra_o` = aa and `fn_o` = oo. A byte 101f_aabb is class 7, with `fn_o` = f, `ra_o` = aa and `rb_o` = bb.
- R6: A byte 110o_aabb with aa different from bb is class 8. Its `fn_o` is {o, second-byte bit 7}, and `imm_o` is second-byte bits 6:0 sign-extended to 8 bits.
- R7: 0xC0 is class 9, with `imm_o` = the second byte. A byte 1101_aabb with aa equal to bb is class 10, with `ra_o` = aa, `fn_o` = second-byte bit 7 and `imm_o` = second-byte bits 6:0 times two.
- R8: A byte 1110_aamm is class 11, 12, 13 or 14 for mm = 0, 1, 2 or 3, with `ra_o` = aa. Class 12 takes `fn_o` = second-byte bits 7:4 and `imm_o` = bits 3:0. The other three take `imm_o` = the second byte.
- R9: A byte 1111_aabb is class 15, with `ra_o` = aa, `rb_o` = bb, `fn_o` = second-byte bits 7:5 (write, push/pop, word) and `imm_o` = bits 4:0.
- R10: `len_o` is 2 when the top bits of the opening byte are 110, 1110 or 1111, and 1 for every other opening byte.
- R11: For a two-byte, non-illegal opening byte with `ext_valid` low, `incomplete_o` is 1 and the class and all fields are zero.
- R12: 0xC5, 0xCA and 0xCF set `illegal_o` and give class 0 with all fields zero, whatever the state of `ext_valid`.
- R13: Any field not assigned by R3 to R9 reads zero. For one-byte instructions, `ext_byte` and `ext_valid` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_byte | input | 8 | Opening instruction byte |
| ext_byte | input | 8 | Follow-on instruction byte |
| ext_valid | input | 1 | Follow-on byte present |
| cls_o | output | 4 | Instruction class |
| ra_o | output | 2 | First register selector |
| rb_o | output | 2 | Second register selector |
| fn_o | output | 4 | Operation or flag field |
| imm_o | output | 8 | Immediate |
| len_o | output | 2 | Length in bytes |
| incomplete_o | output | 1 | Follow-on byte still missing |
| illegal_o | output | 1 | Reserved encoding |

## Verification
Every result appears exactly one clock edge after its inputs, because a single register stage lies between the inputs and the outputs. The bench changes the inputs on the falling edge, waits for the next rising edge, and compares one nanosecond after it. A reset that is applied mid-sweep is checked on the edge right after it. The sweep covers all 256 opening bytes. Two-byte opening bytes are paired with every follow-on byte and with `ext_valid` low. One-byte opening bytes are paired with several follow-on patterns under both states of `ext_valid`, which shows those inputs are ignored.

// File: rtl/vld_pkg.sv
package vld_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;
  localparam int FN_W   = 4;
  localparam int CLS_W  = 4;
  localparam int LEN_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    C_NONE  = 4'd0,  C_HALT  = 4'd1,  C_NOP   = 4'd2,  C_ALU2  = 4'd3,
    C_JALR  = 4'd4,  C_MOVE  = 4'd5,  C_ALU1  = 4'd6,  C_LDST  = 4'd7,
    C_BRNCH = 4'd8,  C_JUMP  = 4'd9,  C_ABSM  = 4'd10, C_ADDI  = 4'd11,
    C_ALUI  = 4'd12, C_LDLO  = 4'd13, C_LDHI  = 4'd14, C_MEMX  = 4'd15
  } cls_e;

  typedef struct packed {
    cls_e              cls;
    logic [SEL_W-1:0]  ra;
    logic [SEL_W-1:0]  rb;
    logic [FN_W-1:0]   fn;
    logic [BYTE_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/vld_short.sv
module vld_short
  import vld_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output dec_t              d
);
  logic [SEL_W-1:0] fa, fb;
  assign fa = op[3:2];
  assign fb = op[1:0];

  always_comb begin
    d = '0;
    if (!op[7]) begin
      if (op == 8'h00)      d.cls = C_HALT;
      else if (op == 8'h10) d.cls = C_NOP;
      else begin
        d.cls = C_ALU2;
        d.fn  = {1'b0, op[6:4]};
        d.ra  = fa;
        d.rb  = fb;
      end
    end else if (op[6:4] == 3'b000) begin
      d.cls = (fa == fb) ? C_JALR : C_MOVE;
      d.ra  = fa;
      d.rb  = fb;
    end else if (op[6:4] == 3'b001) begin
      d.cls = C_ALU1;
      d.ra  = fa;
      d.fn  = {2'b00, op[1:0]};
    end else begin
      d.cls = C_LDST;
      d.fn  = {3'b000, op[4]};
      d.ra  = fa;
      d.rb  = fb;
    end
  end
endmodule

// File: rtl/vld_long.sv
module vld_long
  import vld_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  logic [BYTE_W-1:0] ext,
  output dec_t              d,
  output logic              bad
);
  logic [SEL_W-1:0] fa, fb;
  logic             same;
  assign fa   = op[3:2];
  assign fb   = op[1:0];
  assign same = (fa == fb);

  always_comb begin
    d   = '0;
    bad = 1'b0;
    unique case (op[5:4])
      2'b00, 2'b01: begin
        if (!same) begin
          d.cls = C_BRNCH;
          d.ra  = fa;
          d.rb  = fb;
          d.fn  = {2'b00, op[4], ext[7]};
          d.imm = {ext[6], ext[6:0]};
        end else if (op[4]) begin
          d.cls = C_ABSM;
          d.ra  = fa;
          d.fn  = {3'b000, ext[7]};
          d.imm = {ext[6:0], 1'b0};
        end else if (fa == 2'b00) begin
          d.cls = C_JUMP;
          d.imm = ext;
        end else begin
          bad = 1'b1;
        end
      end
      2'b10: begin
        d.ra = fa;
        unique case (fb)
          2'b00: begin d.cls = C_ADDI; d.imm = ext; end
          2'b01: begin
            d.cls = C_ALUI;
            d.fn  = ext[7:4];
            d.imm = {4'b0000, ext[3:0]};
          end
          2'b10: begin d.cls = C_LDLO; d.imm = ext; end
          default: begin d.cls = C_LDHI; d.imm = ext; end
        endcase
      end
      default: begin
        d.cls = C_MEMX;
        d.ra  = fa;
        d.rb  = fb;
        d.fn  = {1'b0, ext[7:5]};
        d.imm = {3'b000, ext[4:0]};
      end
    endcase
  end
endmodule

// File: rtl/vlen_decoder.sv
module vlen_decoder
  import vld_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] op_byte,
  input  logic [BYTE_W-1:0] ext_byte,
  input  logic              ext_valid,
  output logic [CLS_W-1:0]  cls_o,
  output logic [SEL_W-1:0]  ra_o,
  output logic [SEL_W-1:0]  rb_o,
  output logic [FN_W-1:0]   fn_o,
  output logic [BYTE_W-1:0] imm_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              incomplete_o,
  output logic              illegal_o
);
  dec_t d_short, d_long, d_next, d_q;
  logic bad_long, two_byte;
  logic inc_next, ill_next;
  logic [LEN_W-1:0] len_next;
  logic [LEN_W-1:0] len_q;
  logic inc_q, ill_q;

  vld_short u_short (.op(op_byte), .d(d_short));
  vld_long  u_long  (.op(op_byte), .ext(ext_byte), .d(d_long), .bad(bad_long));

  assign two_byte = (op_byte[7:6] == 2'b11);
  assign len_next = two_byte ? LEN_W'(2) : LEN_W'(1);

  always_comb begin
    d_next   = '0;
    inc_next = 1'b0;
    ill_next = 1'b0;
    if (!two_byte)      d_next   = d_short;
    else if (bad_long)  ill_next = 1'b1;
    else if (!ext_valid) inc_next = 1'b1;
    else                d_next   = d_long;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q   <= '0;
      len_q <= '0;
      inc_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      d_q   <= d_next;
      len_q <= len_next;
      inc_q <= inc_next;
      ill_q <= ill_next;
    end
  end

  assign cls_o        = d_q.cls;
  assign ra_o         = d_q.ra;
  assign rb_o         = d_q.rb;
  assign fn_o         = d_q.fn;
  assign imm_o        = d_q.imm;
  assign len_o        = len_q;
  assign incomplete_o = inc_q;
  assign illegal_o    = ill_q;

  p_halt_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_byte) == 8'h00) |-> cls_o == C_HALT);

  p_alias_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_byte[7:4]) == 4'b1000 &&
     $past(op_byte[3:2]) == $past(op_byte[1:0])) |-> cls_o == C_JALR);

  p_wait_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ext_valid) && $past(op_byte[7:5]) == 3'b111)
      |-> (incomplete_o && cls_o == C_NONE));

  p_len_r10: assert property (@(posedge clk) disable iff (rst)
    (incomplete_o || illegal_o) |-> len_o == LEN_W'(2));

  p_excl_r12: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!incomplete_o && cls_o == C_NONE && imm_o == '0));
endmodule

// File: tb/sim_vlen_decoder.sv
`timescale 1ns/1ps
module sim_vlen_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] op_byte = 8'h00, ext_byte = 8'h00;
  logic ext_valid = 1'b0;
  logic [3:0] cls_o, fn_o;
  logic [1:0] ra_o, rb_o, len_o;
  logic [7:0] imm_o;
  logic incomplete_o, illegal_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vlen_decoder u0 (.clk(clk), .rst(rst), .op_byte(op_byte), .ext_byte(ext_byte),
    .ext_valid(ext_valid), .cls_o(cls_o), .ra_o(ra_o), .rb_o(rb_o), .fn_o(fn_o),
    .imm_o(imm_o), .len_o(len_o), .incomplete_o(incomplete_o), .illegal_o(illegal_o));

  // Packed {cls,ra,rb,fn,imm,len,inc,ill}; class codes as listed in R2.
  function automatic logic [23:0] ref_dec(input logic [7:0] a, input logic [7:0] b,
                                          input logic ev);
    logic [3:0] c, f; logic [1:0] x, y, ln; logic [7:0] im; logic inc, il;
    x = a[3:2]; y = a[1:0]; c = 0; f = 0; im = 0; ln = 1; inc = 0; il = 0;
    casez (a)
      8'h00: c = 1;
      8'h10: c = 2;
      8'b0???????: begin c = 3; f = {1'b0, a[6:4]}; end
      8'b1000????: c = (x == y) ? 4'd4 : 4'd5;
      8'b1001????: begin c = 6; f = {2'b0, a[1:0]}; y = 0; end
      8'b101?????: begin c = 7; f = {3'b0, a[4]}; end
      8'b110?????: begin
        ln = 2;
        if (x != y) begin c = 8; f = {2'b0, a[4], b[7]}; im = {b[6], b[6:0]}; end
        else if (a == 8'hC0) im = b + 8'd0 + 0 * (c = 9);
        else if (a[4]) begin c = 10; f = {3'b0, b[7]}; im = b[6:0] * 2; y = 0; end
        else il = 1;
      end
      8'b1110????: begin
        ln = 2; y = 0; c = 4'd11 + {2'b0, a[1:0]};
        if (a[1:0] == 2'd1) begin f = b[7:4]; im = {4'b0, b[3:0]}; end else im = b;
      end
      default: begin ln = 2; c = 15; f = {1'b0, b[7:5]}; im = {3'b0, b[4:0]}; end
    endcase
    if (il || (ln == 2 && !ev)) begin
      c = 0; x = 0; y = 0; f = 0; im = 0; inc = !il;
    end
    return {c, x, y, f, im, ln, inc, il};
  endfunction

  function automatic string tag_of(input logic [7:0] a, input logic [23:0] e);
    if (e[0]) return "R12";
    if (e[1]) return "R11";
    if (!a[7]) return "R3";
    if (a[7:4] == 4'b1000) return "R4";
    if (a[7:6] == 2'b10) return "R5";
    if (a[7:5] == 3'b110) return (a[3:2] != a[1:0]) ? "R6" : "R7";
    if (a[7:4] == 4'b1110) return "R8";
    return "R9";
  endfunction

  task automatic apply_and_check(input logic [7:0] a, input logic [7:0] b, input logic ev);
    logic [23:0] exp_v, got;
    @(negedge clk);
    op_byte = a; ext_byte = b; ext_valid = ev;
    @(posedge clk); #1;
    exp_v = ref_dec(a, b, ev);
    got = {cls_o, ra_o, rb_o, fn_o, imm_o, len_o, incomplete_o, illegal_o};
    checks++;
    if (got !== exp_v) begin
      failures++;
      $display("FAIL %s op=%h ext=%h ev=%0b got=%h exp=%h", tag_of(a, exp_v), a, b, ev, got, exp_v);
    end
    checks++; // R10 length, R13 unused fields zero (covered by the full compare)
    if (len_o !== exp_v[3:2]) begin
      failures++;
      $display("FAIL R10 op=%h got len=%0d exp=%0d", a, len_o, exp_v[3:2]);
    end
  endtask

  task automatic check_reset();
    @(negedge clk); rst = 1'b1; op_byte = 8'hE5; ext_byte = 8'hFF; ext_valid = 1'b1;
    @(posedge clk); #1;
    checks++;
    if ({cls_o, ra_o, rb_o, fn_o, imm_o, len_o, incomplete_o, illegal_o} !== 24'h0) begin
      failures++;
      $display("FAIL R1 reset got=%h exp=000000",
        {cls_o, ra_o, rb_o, fn_o, imm_o, len_o, incomplete_o, illegal_o});
    end
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    check_reset();
    for (int a = 0; a < 256; a++) begin
      if (a[7:6] == 2'b11) begin
        for (int b = 0; b < 256; b++) apply_and_check(a[7:0], b[7:0], 1'b1);
        apply_and_check(a[7:0], 8'h5A, 1'b0);
      end else begin
        apply_and_check(a[7:0], 8'h00, 1'b0);
        apply_and_check(a[7:0], 8'hFF, 1'b1);
        apply_and_check(a[7:0], 8'hA5, 1'b0);
      end
      if (a == 128) check_reset(); // R1 mid-run
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; failures++;
      $display("FAIL R1 watchdog expired got=hung exp=complete");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule